// File: doc/BRIEF.md
# Operand-Wait Issue Lane with Early Tag Wakeup

This block is one issue lane of an out-of-order core. A steering stage places at most one decoded instruction per cycle into the lane. The instruction carries two source operands, each either already resolved with its value or still waiting on a producer tag. It also carries a destination tag, and it may carry an arithmetic operation, an address-generation operation, or both. The lane keeps up to eight such instructions. It watches every result broadcast in the machine and launches one instruction per cycle, the oldest ready one, to the lane's arithmetic unit and address unit together. The execution units accept every launch.

Results reach the lane on two kinds of bus. The arithmetic units of all lanes announce a result tag one cycle before its data. An instruction whose last missing operand matches such an early tag launches at once. The missing operand is then supplied by a bypass from the data bus in the cycle where the launch is presented. The address units and the load/store units deliver tag and data in the same cycle. Operands from these buses are written into the entry, and the instruction becomes launchable on the following cycle. A flush input empties the lane in one cycle.

Top module: `rs_lane`

## Requirements
- R1: After reset, `disp_ready` is 1 and `lch_valid` is 0.
- R2: An instruction dispatched with both sources ready appears on the launch outputs two clock edges after the edge that accepts it. The launch carries its destination tag and the dispatched source values, with source 0 on `lch_src_val[0]` and source 1 on `lch_src_val[1]`.
- R3: When an early tag matches the last missing source of a held entry in cycle t, that entry is presented with `lch_valid`=1 in cycle t+1. That source's `lch_src_val` equals the `ebc_data` of the matching bus during cycle t+1.
- R4: A late-bus match (tag and data together) in cycle t stores the data. The entry can launch in cycle t+2 with that value.
- R5: Among launchable entries, the one dispatched earliest launches first, whatever slot it occupies.
- R6: `disp_ready` is 0 exactly when all 8 entries are occupied. A `disp_valid` while `disp_ready` is 0 is dropped.
- R7: `flush` empties every entry at the next edge. That edge launches nothing, an instruction offered in the flush cycle is dropped, and `disp_ready` is 1 afterwards.
- R8: The arithmetic enable, address enable and both operation codes of an instruction are presented unchanged at launch, in any combination of the two enables.
- R9: A source whose tag matches an early broadcast in the very cycle it is dispatched takes the data from that bus in the next cycle. It does not need a second broadcast.
- R10: An entry woken by an early tag but not chosen that cycle captures the data from the bus in the following cycle and later launches with that captured value.
- R11: At most one entry launches per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all entries |
| disp_valid | input | 1 | An instruction is offered |
| disp_ready | output | 1 | A free entry exists |
| disp_alu_en | input | 1 | Instruction has an arithmetic part |
| disp_agu_en | input | 1 | Instruction has an address part |
| disp_alu_op | input | OP_W | Arithmetic operation code |
| disp_agu_op | input | OP_W | Address operation code |
| disp_dst | input | TAG_W | Destination tag |
| disp_src_rdy | input | 2 | Per-source value already known |
| disp_src_tag | input | 2*TAG_W | Per-source producer tag |
| disp_src_val | input | 2*DATA_W | Per-source known value |
| ebc_vld | input | N_EARLY | Early tag valid, one per arithmetic result bus |
| ebc_tag | input | N_EARLY*TAG_W | Early tags |
| ebc_data | input | N_EARLY*DATA_W | Data, one cycle after its tag |
| lbc_vld | input | N_LATE | Late bus valid (address and load/store results) |
| lbc_tag | input | N_LATE*TAG_W | Late bus tags |
| lbc_data | input | N_LATE*DATA_W | Late bus data, same cycle as its tag |
| lch_valid | output | 1 | An instruction is launched this cycle |
| lch_alu_en | output | 1 | Launch has an arithmetic part |
| lch_agu_en | output | 1 | Launch has an address part |
| lch_alu_op | output | OP_W | Arithmetic operation code |
| lch_agu_op | output | OP_W | Address operation code |
| lch_dst | output | TAG_W | Destination tag |
| lch_src_val | output | 2*DATA_W | Source operand values |

## Verification
An instruction with ready operands shows up on the launch outputs after the second edge that follows the cycle it is offered. An entry woken by an early tag shows up after the very next edge, and its bypassed operand is read in that same cycle, after the bench has placed the data on the bus. Late-bus wakeups need two edges, and a flush or a dispatch is visible on `disp_ready` after one. All inputs change on the falling edge and every result is read before the next rising edge. Bypassed and captured values are told apart by changing the data bus before the launch is read.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    SRC_WAIT = 2'd0,
    SRC_PEND = 2'd1,
    SRC_HELD = 2'd2
  } src_state_e;
endpackage

// File: rtl/rs_tag_snoop.sv
module rs_tag_snoop #(
  parameter int TAG_W   = 7,
  parameter int DATA_W  = 32,
  parameter int N_EARLY = 3,
  parameter int N_LATE  = 4,
  parameter int EIDX_W  = 2
) (
  input  logic [TAG_W-1:0]                 tag,
  input  logic [N_EARLY-1:0]               e_vld,
  input  logic [N_EARLY-1:0][TAG_W-1:0]    e_tag,
  input  logic [N_LATE-1:0]                l_vld,
  input  logic [N_LATE-1:0][TAG_W-1:0]     l_tag,
  input  logic [N_LATE-1:0][DATA_W-1:0]    l_data,
  output logic                             e_hit,
  output logic [EIDX_W-1:0]                e_idx,
  output logic                             l_hit,
  output logic [DATA_W-1:0]                l_val
);
  always_comb begin
    e_hit = 1'b0;
    e_idx = '0;
    for (int k = N_EARLY - 1; k >= 0; k--) begin
      if (e_vld[k] && (e_tag[k] == tag)) begin
        e_hit = 1'b1;
        e_idx = EIDX_W'(k);
      end
    end
  end

  always_comb begin
    l_hit = 1'b0;
    l_val = '0;
    for (int k = 0; k < N_LATE; k++) begin
      if (l_vld[k] && (l_tag[k] == tag)) begin
        l_hit = 1'b1;
        l_val = l_val | l_data[k];
      end
    end
  end
endmodule

// File: rtl/rs_free_find.sv
module rs_free_find #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] occupied,
  output logic [ENTRIES-1:0] free_oh,
  output logic               full
);
  always_comb begin
    free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occupied[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  assign full = &occupied;
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [ENTRIES-1:0] alloc_oh,
  input  logic [ENTRIES-1:0] req,
  output logic [ENTRIES-1:0] gnt
);
  // before_q[r][c] set: entry r was placed ahead of entry c
  logic [ENTRIES-1:0] before_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ENTRIES; r++) before_q[r] <= '0;
    end else if (alloc_en) begin
      for (int r = 0; r < ENTRIES; r++) begin
        for (int c = 0; c < ENTRIES; c++) begin
          if (alloc_oh[r])      before_q[r][c] <= 1'b0;
          else if (alloc_oh[c]) before_q[r][c] <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_pick
    logic [ENTRIES-1:0] ahead;
    always_comb begin
      for (int j = 0; j < ENTRIES; j++) ahead[j] = before_q[j][i] && (j != i);
    end
    assign gnt[i] = req[i] && !(|(req & ahead));
  end
endmodule

// File: rtl/rs_lane.sv
module rs_lane
  import rs_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 7,
  parameter int DATA_W  = 32,
  parameter int OP_W    = 8,
  parameter int N_EARLY = 3,
  parameter int N_LATE  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             flush,
  input  logic                             disp_valid,
  output logic                             disp_ready,
  input  logic                             disp_alu_en,
  input  logic                             disp_agu_en,
  input  logic [OP_W-1:0]                  disp_alu_op,
  input  logic [OP_W-1:0]                  disp_agu_op,
  input  logic [TAG_W-1:0]                 disp_dst,
  input  logic [NSRC-1:0]                  disp_src_rdy,
  input  logic [NSRC-1:0][TAG_W-1:0]       disp_src_tag,
  input  logic [NSRC-1:0][DATA_W-1:0]      disp_src_val,
  input  logic [N_EARLY-1:0]               ebc_vld,
  input  logic [N_EARLY-1:0][TAG_W-1:0]    ebc_tag,
  input  logic [N_EARLY-1:0][DATA_W-1:0]   ebc_data,
  input  logic [N_LATE-1:0]                lbc_vld,
  input  logic [N_LATE-1:0][TAG_W-1:0]     lbc_tag,
  input  logic [N_LATE-1:0][DATA_W-1:0]    lbc_data,
  output logic                             lch_valid,
  output logic                             lch_alu_en,
  output logic                             lch_agu_en,
  output logic [OP_W-1:0]                  lch_alu_op,
  output logic [OP_W-1:0]                  lch_agu_op,
  output logic [TAG_W-1:0]                 lch_dst,
  output logic [NSRC-1:0][DATA_W-1:0]      lch_src_val
);
  localparam int EIDX_W = (N_EARLY > 1) ? $clog2(N_EARLY) : 1;
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage
  logic [ENTRIES-1:0] ent_vld;
  logic               ent_alu_en [ENTRIES];
  logic               ent_agu_en [ENTRIES];
  logic [OP_W-1:0]    ent_alu_op [ENTRIES];
  logic [OP_W-1:0]    ent_agu_op [ENTRIES];
  logic [TAG_W-1:0]   ent_dst    [ENTRIES];
  src_state_e         ent_st     [ENTRIES][NSRC];
  logic [TAG_W-1:0]   ent_tag    [ENTRIES][NSRC];
  logic [DATA_W-1:0]  ent_val    [ENTRIES][NSRC];
  logic [EIDX_W-1:0]  ent_bus    [ENTRIES][NSRC];

  // snoop results
  logic               e_hit [ENTRIES][NSRC];
  logic [EIDX_W-1:0]  e_idx [ENTRIES][NSRC];
  logic               l_hit [ENTRIES][NSRC];
  logic [DATA_W-1:0]  l_val [ENTRIES][NSRC];
  logic               d_e_hit [NSRC];
  logic [EIDX_W-1:0]  d_e_idx [NSRC];
  logic               d_l_hit [NSRC];
  logic [DATA_W-1:0]  d_l_val [NSRC];

  logic [ENTRIES-1:0] free_oh;
  logic               lane_full;
  logic               disp_fire;
  logic [ENTRIES-1:0] eligible;
  logic [ENTRIES-1:0] pick_gnt;
  logic [SLOT_W-1:0]  pick_idx;
  logic               pick_any;

  // launch registers
  logic [NSRC-1:0]               lch_byp_q;
  logic [EIDX_W-1:0]             lch_bus_q [NSRC];
  logic [NSRC-1:0][DATA_W-1:0]   lch_val_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      rs_tag_snoop #(
        .TAG_W(TAG_W), .DATA_W(DATA_W), .N_EARLY(N_EARLY),
        .N_LATE(N_LATE), .EIDX_W(EIDX_W)
      ) u_snoop (
        .tag(ent_tag[i][s]),
        .e_vld(ebc_vld), .e_tag(ebc_tag),
        .l_vld(lbc_vld), .l_tag(lbc_tag), .l_data(lbc_data),
        .e_hit(e_hit[i][s]), .e_idx(e_idx[i][s]),
        .l_hit(l_hit[i][s]), .l_val(l_val[i][s])
      );
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_dsnoop
    rs_tag_snoop #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .N_EARLY(N_EARLY),
      .N_LATE(N_LATE), .EIDX_W(EIDX_W)
    ) u_snoop (
      .tag(disp_src_tag[s]),
      .e_vld(ebc_vld), .e_tag(ebc_tag),
      .l_vld(lbc_vld), .l_tag(lbc_tag), .l_data(lbc_data),
      .e_hit(d_e_hit[s]), .e_idx(d_e_idx[s]),
      .l_hit(d_l_hit[s]), .l_val(d_l_val[s])
    );
  end

  rs_free_find #(.ENTRIES(ENTRIES)) u_free (
    .occupied(ent_vld), .free_oh(free_oh), .full(lane_full)
  );

  assign disp_ready = !lane_full;
  assign disp_fire  = disp_valid && !lane_full && !flush;

  // an entry may launch when every source is held, pending, or hit by an early tag now
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      eligible[i] = ent_vld[i];
      for (int s = 0; s < NSRC; s++) begin
        if (ent_st[i][s] == SRC_WAIT && !e_hit[i][s]) eligible[i] = 1'b0;
      end
    end
  end

  rs_age_pick #(.ENTRIES(ENTRIES)) u_age (
    .clk(clk), .rst(rst),
    .alloc_en(disp_fire), .alloc_oh(free_oh),
    .req(eligible), .gnt(pick_gnt)
  );

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (pick_gnt[i]) pick_idx = SLOT_W'(i);
    end
  end
  assign pick_any = |pick_gnt;

  // entry state
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        for (int s = 0; s < NSRC; s++) ent_st[i][s] <= SRC_WAIT;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int s = 0; s < NSRC; s++) begin
          case (ent_st[i][s])
            SRC_PEND: begin
              ent_val[i][s] <= ebc_data[ent_bus[i][s]];
              ent_st[i][s]  <= SRC_HELD;
            end
            SRC_WAIT: begin
              if (e_hit[i][s]) begin
                ent_st[i][s]  <= SRC_PEND;
                ent_bus[i][s] <= e_idx[i][s];
              end else if (l_hit[i][s]) begin
                ent_st[i][s]  <= SRC_HELD;
                ent_val[i][s] <= l_val[i][s];
              end
            end
            default: ;
          endcase
        end
        if (disp_fire && free_oh[i]) begin
          ent_alu_en[i] <= disp_alu_en;
          ent_agu_en[i] <= disp_agu_en;
          ent_alu_op[i] <= disp_alu_op;
          ent_agu_op[i] <= disp_agu_op;
          ent_dst[i]    <= disp_dst;
          for (int s = 0; s < NSRC; s++) begin
            ent_tag[i][s] <= disp_src_tag[s];
            if (disp_src_rdy[s]) begin
              ent_st[i][s]  <= SRC_HELD;
              ent_val[i][s] <= disp_src_val[s];
            end else if (d_e_hit[s]) begin
              ent_st[i][s]  <= SRC_PEND;
              ent_bus[i][s] <= d_e_idx[s];
            end else if (d_l_hit[s]) begin
              ent_st[i][s]  <= SRC_HELD;
              ent_val[i][s] <= d_l_val[s];
            end else begin
              ent_st[i][s]  <= SRC_WAIT;
            end
          end
        end
      end
      if (flush) ent_vld <= '0;
      else       ent_vld <= (ent_vld & ~pick_gnt) | (disp_fire ? free_oh : '0);
    end
  end

  // launch stage
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      lch_valid <= 1'b0;
      lch_byp_q <= '0;
    end else begin
      lch_valid <= pick_any;
      lch_byp_q <= '0;
      if (pick_any) begin
        lch_alu_en <= ent_alu_en[pick_idx];
        lch_agu_en <= ent_agu_en[pick_idx];
        lch_alu_op <= ent_alu_op[pick_idx];
        lch_agu_op <= ent_agu_op[pick_idx];
        lch_dst    <= ent_dst[pick_idx];
        for (int s = 0; s < NSRC; s++) begin
          case (ent_st[pick_idx][s])
            SRC_WAIT: begin
              lch_byp_q[s] <= 1'b1;
              lch_bus_q[s] <= e_idx[pick_idx][s];
            end
            SRC_PEND: lch_val_q[s] <= ebc_data[ent_bus[pick_idx][s]];
            default:  lch_val_q[s] <= ent_val[pick_idx][s];
          endcase
        end
      end
    end
  end

  // bypass: data follows its early tag by one cycle
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      lch_src_val[s] = lch_byp_q[s] ? ebc_data[lch_bus_q[s]] : lch_val_q[s];
    end
  end
endmodule

// File: rtl/rs_lane_check.sv
module rs_lane_check #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               disp_valid,
  input logic               disp_ready,
  input logic               lch_valid,
  input logic [ENTRIES-1:0] pick_gnt
);
  localparam int OCC_W = $clog2(ENTRIES + 1);
  logic [OCC_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst || flush) occ <= '0;
    else occ <= occ + OCC_W'(disp_valid && disp_ready) - OCC_W'(|pick_gnt);
  end

  a_r6_ready_tracks_occupancy: assert property (@(posedge clk) disable iff (rst)
    disp_ready == (occ != OCC_W'(ENTRIES)));

  a_r6_no_overfill: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(ENTRIES));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (disp_ready && !lch_valid));

  a_r11_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_gnt));

  a_r2_grant_launches: assert property (@(posedge clk) disable iff (rst)
    (|pick_gnt && !flush) |=> lch_valid);

  a_r2_grant_needs_entry: assert property (@(posedge clk) disable iff (rst)
    (|pick_gnt) |-> (occ != '0));
endmodule

bind rs_lane rs_lane_check #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .flush(flush),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .lch_valid(lch_valid), .pick_gnt(pick_gnt)
);

// File: tb/rs_lane_test.sv
module rs_lane_test;
  localparam int TW = 7;
  localparam int DW = 32;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst, flush;
  logic disp_valid, disp_ready, disp_alu_en, disp_agu_en;
  logic [OW-1:0] disp_alu_op, disp_agu_op;
  logic [TW-1:0] disp_dst;
  logic [1:0] disp_src_rdy;
  logic [1:0][TW-1:0] disp_src_tag;
  logic [1:0][DW-1:0] disp_src_val;
  logic [2:0] ebc_vld;
  logic [2:0][TW-1:0] ebc_tag;
  logic [2:0][DW-1:0] ebc_data;
  logic [3:0] lbc_vld;
  logic [3:0][TW-1:0] lbc_tag;
  logic [3:0][DW-1:0] lbc_data;
  logic lch_valid, lch_alu_en, lch_agu_en;
  logic [OW-1:0] lch_alu_op, lch_agu_op;
  logic [TW-1:0] lch_dst;
  logic [1:0][DW-1:0] lch_src_val;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rs_lane uut (.*);

  typedef struct packed {
    logic          alu_en;
    logic          agu_en;
    logic [OW-1:0] alu_op;
    logic [OW-1:0] agu_op;
    logic [TW-1:0] dst;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 8'h11, 8'h00, 7'h01, 32'h0000_0001, 32'h0000_0002},
    '{1'b0, 1'b1, 8'h00, 8'h22, 7'h02, 32'hFFFF_FFFF, 32'h8000_0000},
    '{1'b1, 1'b1, 8'h33, 8'h44, 7'h03, 32'h1234_5678, 32'h9ABC_DEF0},
    '{1'b1, 1'b1, 8'hFF, 8'hFE, 7'h7F, 32'h0000_0000, 32'h0000_0000},
    '{1'b0, 1'b1, 8'h5A, 8'hA5, 7'h40, 32'hDEAD_BEEF, 32'h0BAD_F00D},
    '{1'b1, 1'b0, 8'h01, 8'h80, 7'h00, 32'h5555_AAAA, 32'hAAAA_5555}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 1'b0; disp_valid = 1'b0; disp_alu_en = 1'b0; disp_agu_en = 1'b0;
    disp_alu_op = '0; disp_agu_op = '0; disp_dst = '0; disp_src_rdy = '0;
    disp_src_tag = '0; disp_src_val = '0;
    ebc_vld = '0; ebc_tag = '0; lbc_vld = '0; lbc_tag = '0; lbc_data = '0;
  endtask

  task automatic offer(input logic [TW-1:0] dst, input logic ra, input logic [TW-1:0] ta,
                       input logic [DW-1:0] va, input logic rb, input logic [TW-1:0] tb,
                       input logic [DW-1:0] vb);
    disp_valid = 1'b1; disp_alu_en = 1'b1; disp_agu_en = 1'b0;
    disp_alu_op = 8'h0C; disp_agu_op = 8'h00; disp_dst = dst;
    disp_src_rdy = {rb, ra}; disp_src_tag[0] = ta; disp_src_tag[1] = tb;
    disp_src_val[0] = va; disp_src_val[1] = vb;
  endtask

  initial begin
    idle();
    ebc_data = '0;
    rst = 1'b1;
    step(); step(); step();
    rst = 1'b0;
    step();
    check(disp_ready == 1'b1, "R1 reset ready", 64'(disp_ready), 64'd1);
    check(lch_valid == 1'b0, "R1 reset launch", 64'(lch_valid), 64'd0);

    // table: ready operands, launch two edges later (R2, R8)
    foreach (VECS[i]) begin
      disp_valid = 1'b1; disp_alu_en = VECS[i].alu_en; disp_agu_en = VECS[i].agu_en;
      disp_alu_op = VECS[i].alu_op; disp_agu_op = VECS[i].agu_op; disp_dst = VECS[i].dst;
      disp_src_rdy = 2'b11; disp_src_val[0] = VECS[i].a; disp_src_val[1] = VECS[i].b;
      step();
      idle();
      check(lch_valid == 1'b0, "R2 not before second edge", 64'(lch_valid), 64'd0);
      step();
      check(lch_valid == 1'b1, "R2 launch valid", 64'(lch_valid), 64'd1);
      check(lch_dst == VECS[i].dst, "R2 dst", 64'(lch_dst), 64'(VECS[i].dst));
      check(lch_src_val[0] == VECS[i].a, "R2 src0", 64'(lch_src_val[0]), 64'(VECS[i].a));
      check(lch_src_val[1] == VECS[i].b, "R2 src1", 64'(lch_src_val[1]), 64'(VECS[i].b));
      check({lch_alu_en, lch_agu_en} == {VECS[i].alu_en, VECS[i].agu_en}, "R8 enables",
            64'({lch_alu_en, lch_agu_en}), 64'({VECS[i].alu_en, VECS[i].agu_en}));
      check({lch_alu_op, lch_agu_op} == {VECS[i].alu_op, VECS[i].agu_op}, "R8 opcodes",
            64'({lch_alu_op, lch_agu_op}), 64'({VECS[i].alu_op, VECS[i].agu_op}));
      step();
      check(lch_valid == 1'b0, "R11 single launch", 64'(lch_valid), 64'd0);
    end

    // R3 early wakeup and bypass
    offer(7'h31, 1'b1, 7'h00, 32'h1234, 1'b0, 7'h30, 32'h0);
    step(); idle(); step();
    check(lch_valid == 1'b0, "R3 waits for tag", 64'(lch_valid), 64'd0);
    ebc_vld[2] = 1'b1; ebc_tag[2] = 7'h30;
    step();
    check(lch_valid == 1'b1, "R3 launch after tag", 64'(lch_valid), 64'd1);
    ebc_vld = '0; ebc_data[2] = 32'hCAFE_0001;
    #1;
    check(lch_src_val[1] == 32'hCAFE_0001, "R3 bypass data", 64'(lch_src_val[1]), 64'hCAFE_0001);
    check(lch_src_val[0] == 32'h1234, "R3 held src", 64'(lch_src_val[0]), 64'h1234);
    step();
    ebc_data = '0;

    // R9 early tag in dispatch cycle
    offer(7'h36, 1'b0, 7'h35, 32'h0, 1'b1, 7'h00, 32'h7);
    ebc_vld[1] = 1'b1; ebc_tag[1] = 7'h35;
    step(); idle();
    ebc_data[1] = 32'hD00D_0009;
    step();
    ebc_data[1] = 32'h0000_0BAD;
    #1;
    check(lch_valid == 1'b1 && lch_dst == 7'h36, "R9 launch", 64'(lch_dst), 64'h36);
    check(lch_src_val[0] == 32'hD00D_0009, "R9 captured", 64'(lch_src_val[0]), 64'hD00D_0009);
    step();
    ebc_data = '0;

    // R10 woken but not chosen, captures data next cycle
    offer(7'h51, 1'b0, 7'h41, 32'h0, 1'b1, 7'h00, 32'h1);
    step();
    offer(7'h52, 1'b0, 7'h42, 32'h0, 1'b1, 7'h00, 32'h2);
    step(); idle(); step();
    ebc_vld[0] = 1'b1; ebc_tag[0] = 7'h41; ebc_vld[1] = 1'b1; ebc_tag[1] = 7'h42;
    step();
    ebc_vld = '0; ebc_data[0] = 32'hAAAA_0000; ebc_data[1] = 32'hBBBB_0000;
    #1;
    check(lch_dst == 7'h51, "R10 older first", 64'(lch_dst), 64'h51);
    check(lch_src_val[0] == 32'hAAAA_0000, "R10 first bypass", 64'(lch_src_val[0]), 64'hAAAA_0000);
    step();
    ebc_data = '0;
    #1;
    check(lch_valid == 1'b1 && lch_dst == 7'h52, "R10 second launch", 64'(lch_dst), 64'h52);
    check(lch_src_val[0] == 32'hBBBB_0000, "R10 captured", 64'(lch_src_val[0]), 64'hBBBB_0000);
    step();

    // R5 age beats slot index, R4 late bus
    offer(7'h11, 1'b1, 7'h00, 32'h0, 1'b1, 7'h00, 32'h0);
    step();
    offer(7'h12, 1'b1, 7'h00, 32'h0, 1'b0, 7'h21, 32'h0);
    step();
    check(lch_dst == 7'h11, "R5 first ready", 64'(lch_dst), 64'h11);
    offer(7'h13, 1'b1, 7'h00, 32'h0, 1'b0, 7'h21, 32'h0);
    step(); idle();
    lbc_vld[3] = 1'b1; lbc_tag[3] = 7'h21; lbc_data[3] = 32'h0000_BEEF;
    step(); idle();
    check(lch_valid == 1'b0, "R4 not same edge", 64'(lch_valid), 64'd0);
    step();
    check(lch_valid == 1'b1 && lch_dst == 7'h12, "R5 oldest in higher slot", 64'(lch_dst), 64'h12);
    check(lch_src_val[1] == 32'h0000_BEEF, "R4 late data", 64'(lch_src_val[1]), 64'hBEEF);
    step();
    check(lch_valid == 1'b1 && lch_dst == 7'h13, "R5 younger next", 64'(lch_dst), 64'h13);
    step();

    // R6 full lane
    for (int i = 0; i < 8; i++) begin
      offer(7'(i + 1), 1'b1, 7'h00, 32'(100 + i), 1'b0, 7'h60, 32'h0);
      step();
    end
    idle();
    check(disp_ready == 1'b0, "R6 full", 64'(disp_ready), 64'd0);
    offer(7'h7E, 1'b1, 7'h00, 32'h0, 1'b1, 7'h00, 32'h0);
    step(); idle();
    check(lch_valid == 1'b0, "R6 dropped offer", 64'(lch_valid), 64'd0);
    lbc_vld[0] = 1'b1; lbc_tag[0] = 7'h60; lbc_data[0] = 32'h0000_6060;
    step(); idle();
    for (int i = 0; i < 8; i++) begin
      step();
      check(lch_valid == 1'b1 && lch_dst == 7'(i + 1), "R5 R11 drain order", 64'(lch_dst), 64'(i + 1));
      check(lch_src_val[0] == 32'(100 + i), "R6 drain src", 64'(lch_src_val[0]), 64'(100 + i));
    end
    step();
    check(lch_valid == 1'b0, "R6 offer never stored", 64'(lch_valid), 64'd0);
    check(disp_ready == 1'b1, "R6 ready again", 64'(disp_ready), 64'd1);

    // R7 flush
    offer(7'h71, 1'b1, 7'h00, 32'h0, 1'b0, 7'h50, 32'h0);
    step();
    offer(7'h72, 1'b1, 7'h00, 32'h0, 1'b1, 7'h00, 32'h0);
    step();
    offer(7'h73, 1'b1, 7'h00, 32'h0, 1'b1, 7'h00, 32'h0);
    flush = 1'b1;
    step(); idle();
    check(lch_valid == 1'b0, "R7 flush blocks launch", 64'(lch_valid), 64'd0);
    check(disp_ready == 1'b1, "R7 ready after flush", 64'(disp_ready), 64'd1);
    lbc_vld[1] = 1'b1; lbc_tag[1] = 7'h50; lbc_data[1] = 32'h5;
    step(); idle();
    for (int i = 0; i < 3; i++) begin
      step();
      check(lch_valid == 1'b0, "R7 entries gone", 64'(lch_valid), 64'd0);
    end
    offer(7'h74, 1'b1, 7'h00, 32'h74, 1'b1, 7'h00, 32'h0);
    step(); idle(); step();
    check(lch_valid == 1'b1 && lch_dst == 7'h74, "R7 usable after flush", 64'(lch_dst), 64'h74);
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule